// File: doc/BRIEF.md
# Partitioned Byte-Wide Memory Decoder

This block turns each processor memory request, either an instruction fetch or a data access, into the chip-select, write-strobe and address lines of a non-multiplexed byte-wide SRAM bus. The lower 32 KB of the address space, for program and data alike, maps onto the SRAM behind the primary select. A second 32 KB bank behind a secondary select holds data only. Any other access is flagged for the multiplexed expansion port. All strobes are active-low.

A boundary register splits the shared lower window into two parts. Below the boundary is a code region that refuses writes. From the boundary up is a writable data region. Software can reload the boundary at any time, with a granularity of 4 KB. A hold input, driven by reset or power-fail logic, forces every strobe inactive. A registered flag reports each write that the protection suppressed. The two top SRAM address lines are driven inverted.

The decode path is combinational from the request to the bus outputs. Only the boundary register and the violation flag are clocked.

Top module: `bwdec_top`

## Requirements
- R1: A valid request with req_addr below 8000h, which is not a data access with req_bank2 set, drives sel1_n low and sel2_n high, and keeps to_port low.
- R2: A valid request with req_addr at 8000h or above, which is not a data access with req_bank2 set, drives to_port high and keeps sel1_n and sel2_n high.
- R3: A data write to the primary window drives wr_n low only when req_addr[14:12] is at or above the boundary in 4 KB units; otherwise wr_n stays high. Data reads of the code region still select with wr_n high.
- R4: The boundary register loads bound_val[15:12] on a clock edge where bound_ld is high, and takes effect from the next cycle. Any value of 8000h or above clamps to the whole window. After reset the whole window is code.
- R5: A data access with req_bank2 set drives sel2_n low at any address and keeps sel1_n high and to_port low. A write there drives wr_n low with no protection.
- R6: An instruction fetch (req_code high) never asserts sel2_n or wr_n, whatever req_bank2 and req_write are.
- R7: sram_addr[14:13] carry the inverse of req_addr[14:13], and sram_addr[12:0] carry req_addr[12:0] unchanged.
- R8: While hold or rst is high, sel1_n, sel2_n and wr_n are all 1 and to_port is 0.
- R9: wp_hit is high for exactly the cycle after an edge at which a data write to the primary window was suppressed by the boundary, and low otherwise.
- R10: With req_valid low, all selects and wr_n are 1 and to_port is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also forces strobes inactive |
| hold | input | 1 | Power-fail or reset hold; forces strobes inactive |
| req_valid | input | 1 | Request present this cycle |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = data write |
| req_bank2 | input | 1 | Data bank-select control bit |
| req_addr | input | 16 | Logical address |
| bound_ld | input | 1 | Load the boundary register |
| bound_val | input | 16 | New boundary address, 4 KB granular |
| sel1_n | output | 1 | Primary SRAM chip select, active low |
| sel2_n | output | 1 | Data-only bank chip select, active low |
| wr_n | output | 1 | SRAM write strobe, active low |
| to_port | output | 1 | Access belongs on the expansion port |
| sram_addr | output | 15 | SRAM address with top two bits inverted |
| wp_hit | output | 1 | Registered write-protect violation flag |

## Verification
The bench sets the boundary at 3000h and probes both sides of it: 2FFFh must refuse a write and 3000h must accept one. An off-by-one compare would either let the top 4 KB page of code be overwritten or lock out the first page of data. It also loads values of 8000h, F000h and 0000h. A design that drops bit 15 in the clamp would treat F000h as 7000h and leave the last page writable. It further checks that a load only changes decoding on the next cycle, and that bank-2 requests reach the secondary select at addresses above 8000h without leaking onto the port. Instruction fetches with the bank bit and the write bit set must still read from the primary select. The hold input must mask a write even when that write is otherwise legal.

// File: rtl/bwdec_pkg.sv
package bwdec_pkg;

    localparam int ADDR_W   = 16;                 // logical address width
    localparam int BA_W     = 15;                 // byte-wide SRAM address width
    localparam int GRAN_LSB = 12;                 // boundary granularity (4 KB)
    localparam int INV_TOP  = 2;                  // number of top SRAM lines inverted
    localparam int UNIT_W   = ADDR_W - GRAN_LSB;  // boundary register width
    localparam int IDX_W    = BA_W - GRAN_LSB;    // page index width inside window
    localparam logic [UNIT_W-1:0] FULL_UNITS = UNIT_W'(1 << IDX_W);

    typedef struct packed {
        logic              valid;
        logic              is_code;
        logic              write;
        logic              bank2;
        logic [ADDR_W-1:0] addr;
    } req_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SEL1 = 2'd1,
        TGT_SEL2 = 2'd2,
        TGT_PORT = 2'd3
    } tgt_e;

    function automatic logic in_window(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:BA_W] == '0;
    endfunction

    function automatic logic [UNIT_W-1:0] clamp_units(logic [ADDR_W-1:0] v);
        logic [UNIT_W-1:0] u;
        u = v[ADDR_W-1:GRAN_LSB];
        return (u >= FULL_UNITS) ? FULL_UNITS : u;
    endfunction

    function automatic logic [UNIT_W-1:0] page_of(logic [ADDR_W-1:0] a);
        return UNIT_W'(a[BA_W-1:GRAN_LSB]);
    endfunction

endpackage

// File: rtl/bwdec_bound_reg.sv
module bwdec_bound_reg
    import bwdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] val,
    output logic [UNIT_W-1:0] bound
);

    always_ff @(posedge clk) begin
        if (rst)
            bound <= FULL_UNITS;
        else if (ld)
            bound <= clamp_units(val);
    end

    // R4: boundary never exceeds the window and only moves on a load
    a_r4_bound_range: assert property (@(posedge clk) disable iff (rst)
        bound <= FULL_UNITS);
    a_r4_bound_stable: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(bound));

endmodule

// File: rtl/bwdec_route.sv
module bwdec_route
    import bwdec_pkg::*;
(
    input  req_t              req,
    input  logic              hold,
    input  logic [UNIT_W-1:0] bound,
    output tgt_e              tgt,
    output logic              prot
);

    always_comb begin
        tgt = TGT_NONE;
        if (!hold && req.valid) begin
            if (!req.is_code && req.bank2)
                tgt = TGT_SEL2;
            else if (in_window(req.addr))
                tgt = TGT_SEL1;
            else
                tgt = TGT_PORT;
        end
    end

    assign prot = page_of(req.addr) < bound;

endmodule

// File: rtl/bwdec_strobe.sv
module bwdec_strobe
    import bwdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req,
    input  logic hold,
    input  tgt_e tgt,
    input  logic prot,
    output logic sel1_n,
    output logic sel2_n,
    output logic wr_n,
    output logic to_port,
    output logic blocked
);

    logic data_wr;
    logic wr_ok;

    assign data_wr = req.write && !req.is_code;

    always_comb begin
        sel1_n  = (tgt != TGT_SEL1);
        sel2_n  = (tgt != TGT_SEL2);
        to_port = (tgt == TGT_PORT);
        wr_ok   = data_wr && ((tgt == TGT_SEL2) || (tgt == TGT_SEL1 && !prot));
        wr_n    = !wr_ok;
        blocked = data_wr && (tgt == TGT_SEL1) && prot;
    end

    // R3: a selected protected page never sees the write strobe
    a_r3_no_write_in_code: assert property (@(posedge clk) disable iff (rst)
        (!sel1_n && prot) |-> wr_n);
    // R6: fetches are read-only and never use the data-only bank
    a_r6_fetch_read_only: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.is_code) |-> (wr_n && sel2_n));
    // R8: hold masks every strobe
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        hold |-> (sel1_n && sel2_n && wr_n && !to_port));
    // R5: at most one destination per cycle
    a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!sel1_n, !sel2_n, to_port}));
    // R10: no request, no activity
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req.valid |-> (sel1_n && sel2_n && wr_n && !to_port));

endmodule

// File: rtl/bwdec_top.sv
module bwdec_top
    import bwdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              req_valid,
    input  logic              req_code,
    input  logic              req_write,
    input  logic              req_bank2,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              bound_ld,
    input  logic [ADDR_W-1:0] bound_val,
    output logic              sel1_n,
    output logic              sel2_n,
    output logic              wr_n,
    output logic              to_port,
    output logic [BA_W-1:0]   sram_addr,
    output logic              wp_hit
);

    req_t              req;
    logic              quiet;
    logic [UNIT_W-1:0] bound;
    tgt_e              tgt;
    logic              prot;
    logic              blocked;

    assign req   = '{valid: req_valid, is_code: req_code, write: req_write,
                     bank2: req_bank2, addr: req_addr};
    assign quiet = hold || rst;

    bwdec_bound_reg u_bound (
        .clk   (clk),
        .rst   (rst),
        .ld    (bound_ld),
        .val   (bound_val),
        .bound (bound)
    );

    bwdec_route u_route (
        .req   (req),
        .hold  (quiet),
        .bound (bound),
        .tgt   (tgt),
        .prot  (prot)
    );

    bwdec_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .hold    (quiet),
        .tgt     (tgt),
        .prot    (prot),
        .sel1_n  (sel1_n),
        .sel2_n  (sel2_n),
        .wr_n    (wr_n),
        .to_port (to_port),
        .blocked (blocked)
    );

    // Address lines: the top INV_TOP lines are inverted, the rest pass through
    genvar gi;
    generate
        for (gi = 0; gi < BA_W; gi++) begin : g_ba
            if (gi >= BA_W - INV_TOP) begin : g_inv
                assign sram_addr[gi] = ~req_addr[gi];
            end else begin : g_pass
                assign sram_addr[gi] = req_addr[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            wp_hit <= 1'b0;
        else
            wp_hit <= blocked;
    end

    // R9: a suppressed data write to the primary window is reported next cycle
    a_r9_hit_follows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_code && req_write && !sel1_n && wr_n) |=> wp_hit);
    // R9: no report without a write attempt in the previous cycle
    a_r9_hit_needs_write: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> !wp_hit);
    // R7: inverted lines are the complement of the logical bits
    a_r7_top_inverted: assert property (@(posedge clk) disable iff (rst)
        sram_addr[BA_W-1] != req_addr[BA_W-1]);

endmodule

// File: tb/tb_bwdec_top.sv
module tb_bwdec_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        hold;
    logic        req_valid, req_code, req_write, req_bank2;
    logic [15:0] req_addr;
    logic        bound_ld;
    logic [15:0] bound_val;
    logic        sel1_n, sel2_n, wr_n, to_port, wp_hit;
    logic [14:0] sram_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bwdec_top dut (
        .clk(clk), .rst(rst), .hold(hold),
        .req_valid(req_valid), .req_code(req_code), .req_write(req_write),
        .req_bank2(req_bank2), .req_addr(req_addr),
        .bound_ld(bound_ld), .bound_val(bound_val),
        .sel1_n(sel1_n), .sel2_n(sel2_n), .wr_n(wr_n), .to_port(to_port),
        .sram_addr(sram_addr), .wp_hit(wp_hit)
    );

    // {code, write, bank2, addr[15:0], sel1_n, sel2_n, wr_n, to_port}
    // boundary is 3000h while this table runs
    localparam int NV = 11;
    localparam logic [22:0] VEC [NV] = '{
        {3'b100, 16'h0100, 4'b0110},   // R1 R6 fetch in window
        {3'b111, 16'h0100, 4'b0110},   // R6 fetch ignores write and bank bit
        {3'b100, 16'h8000, 4'b1111},   // R2 fetch above window
        {3'b010, 16'h2FFF, 4'b0110},   // R3 last code byte, write refused
        {3'b010, 16'h3000, 4'b0100},   // R3 first data byte, write allowed
        {3'b000, 16'h1000, 4'b0110},   // R3 read of code region
        {3'b010, 16'h7FFF, 4'b0100},   // R1 R3 top of window
        {3'b010, 16'h9000, 4'b1111},   // R2 data above window
        {3'b011, 16'h0123, 4'b1000},   // R5 bank-2 write low address
        {3'b001, 16'hF000, 4'b1010},   // R5 bank-2 read high address
        {3'b000, 16'h8000, 4'b1111}    // R2 data read at window edge
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic w,
                         input logic b, input logic [15:0] a);
        req_valid = v; req_code = c; req_write = w; req_bank2 = b; req_addr = a;
    endtask

    task automatic chk_bus(input string tag, input logic [3:0] exp);
        chk(tag, {12'h0, sel1_n, sel2_n, wr_n, to_port}, {12'h0, exp});
    endtask

    task automatic load_bound(input logic [15:0] v);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        bound_ld = 1'b1; bound_val = v;
        @(negedge clk);
        bound_ld = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hold = 1'b0; bound_ld = 1'b0; bound_val = 16'h0;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h4000);
        @(negedge clk); @(negedge clk);
        #5;
        chk_bus("R8 reset masks strobes", 4'b1110);
        chk("R9 flag clear in reset", {15'h0, wp_hit}, 16'h0);

        // reset value: whole window is code
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h7000);
        #5;
        chk_bus("R4 reset boundary protects 7000h", 4'b0110);
        @(posedge clk); #5;
        chk("R9 flag after refused write", {15'h0, wp_hit}, 16'h1);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h7000);
        #5;
        chk_bus("R10 idle strobes", 4'b1110);
        @(posedge clk); #5;
        chk("R9 flag drops after one cycle", {15'h0, wp_hit}, 16'h0);

        // load takes effect only after the edge
        @(negedge clk);
        bound_ld = 1'b1; bound_val = 16'h3000;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h5000);
        #5;
        chk_bus("R4 old boundary until edge", 4'b0110);
        @(negedge clk);
        bound_ld = 1'b0;
        #5;
        chk_bus("R4 new boundary after edge", 4'b0100);
        @(posedge clk); #5;
        chk("R9 no flag for allowed write", {15'h0, wp_hit}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:4]);
            #5;
            chk_bus($sformatf("R1 R2 R3 R5 R6 vector %0d", i), VEC[i][3:0]);
            chk($sformatf("R7 address vector %0d", i), {1'b0, sram_addr},
                {1'b0, ~VEC[i][18], ~VEC[i][17], VEC[i][16:4]});
        end

        // R7 explicit corners
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
        #5;
        chk("R7 address 0000h", {1'b0, sram_addr}, 16'h6000);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h7FFF);
        #5;
        chk("R7 address 7FFFh", {1'b0, sram_addr}, 16'h1FFF);

        // R8 hold masks an otherwise legal write
        @(negedge clk);
        hold = 1'b1;
        drive(1'b1, 1'b0, 1'b1, 1'b1, 16'h0040);
        #5;
        chk_bus("R8 hold masks bank-2 write", 4'b1110);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'hC000);
        #5;
        chk_bus("R8 hold masks port access", 4'b1110);
        @(negedge clk);
        hold = 1'b0;

        // R4 clamp: F000h and 8000h both protect the whole window
        load_bound(16'hF000);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h7FFF);
        #5;
        chk_bus("R4 F000h clamps to full window", 4'b0110);
        load_bound(16'h8000);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h7000);
        #5;
        chk_bus("R4 8000h protects whole window", 4'b0110);

        // R3 zero boundary: nothing protected
        load_bound(16'h0000);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
        #5;
        chk_bus("R3 zero boundary allows 0000h", 4'b0100);
        @(posedge clk); #5;
        chk("R9 no flag with zero boundary", {15'h0, wp_hit}, 16'h0);

        // R3 low bits of the load are dropped (4 KB granularity)
        load_bound(16'h2FFF);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h2000);
        #5;
        chk_bus("R3 granular boundary 2FFFh acts as 2000h", 4'b0100);

        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule